// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides a feedback clock by a ratio whose long-run average is an integer part plus a rational fraction, `INT + FRAC/MOD`. The feedback events reach the block as one-cycle tick strobes in the system clock domain. There are two sources: the raw oscillator path and the post-divider path. A select input decides which one is counted. A programmable down-counter counts the selected ticks. When a division completes, the counter emits a one-cycle pulse and immediately loads the length of the next division.

In fractional operation, a third-order cascade of three modulo-`MOD` accumulators sets each new division length. The three accumulators feed an error-cancelling difference network, so every division is `INT` plus an offset between -3 and +4. The offsets sum to the fraction over time. In integer operation, or when the numerator is zero, the modulator is held cleared and every division is exactly `INT`. Each division takes its length from the control values present at the clock edge that ends the previous division. The division in progress is never altered.

Top module: `fracn_fb_divider`

## Requirements
- R1: While `rst` is high, `div_pulse` and `div_len` are 0.
- R2: With `frac_en` = 0, every division spans exactly `int_val` selected ticks, whatever `frac_val` and `mod_val` hold.
- R3: With `src_sel` = 0 only `tick_direct` is counted; with `src_sel` = 1 only `tick_divided` is counted; a pulse always follows a selected tick.
- R4: With `frac_en` = 1 and `frac_val` = 0, every division spans exactly `int_val` ticks.
- R5: In fractional operation (`frac_en` = 1, 0 < `frac_val` < `mod_val`, `mod_val` >= 2, `int_val` >= 4), each division spans between `int_val`-3 and `int_val`+4 ticks.
- R6: Starting from a cleared modulator, the total tick count of n consecutive fractional divisions, with n a multiple of `mod_val`, is within 3 of n*`int_val` + n*`frac_val`/`mod_val`.
- R7: Control values present at the edge that ends a division set the next division. A change made in the cycle after a pulse leaves the division then in progress at its old length and applies to the one after it.
- R8: Changes to `int_val` in the middle of a division that are undone before it ends have no effect on that division's length. Without a selected tick, `div_len` holds and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_direct | input | 1 | Feedback event from the oscillator path, one cycle per edge |
| tick_divided | input | 1 | Feedback event from the output-divider path |
| src_sel | input | 1 | 0 counts `tick_direct`, 1 counts `tick_divided` |
| frac_en | input | 1 | 1 enables fractional operation, 0 gives integer division |
| int_val | input | INT_W | Integer part of the division ratio |
| frac_val | input | MOD_W | Fractional numerator |
| mod_val | input | MOD_W | Fractional modulus |
| div_pulse | output | 1 | One-cycle pulse per completed division, registered |
| div_len | output | INT_W | Length of the division in progress, registered |

## Verification
Integer runs check a constant tick count per division. A nonzero numerator is applied during these runs, so any leak from the modulator into integer mode would show up. The same counting is repeated with the slower post-divider strobe selected, to tell the two sources apart, and with a zero numerator in fractional mode. Two fractional runs with different moduli (3/8 and 5/7) bound each division individually and compare the windowed sum against the exact rational target. A wrong accumulator, carry or difference term shifts that sum even when individual lengths look plausible. Control changes are made right after a pulse and also mid-division, which separates the intended one-division latency from an unguarded immediate load.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  // Order of the cascaded noise-shaping modulator.
  localparam int ORDER = 3;
  // Offset added to the integer part; a third-order cascade spans -3..+4.
  typedef logic signed [3:0] offset_t;
endpackage

// File: rtl/fnd_accum.sv
// One modulo-M accumulator stage: residue register, carry on wrap.
module fnd_accum #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clear,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] residue_next,
  output logic         carry
);
  logic [W-1:0] residue_q;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, residue_q} + {1'b0, addend};
    carry = (sum >= {1'b0, modulus});
    if (carry) residue_next = W'(sum - {1'b0, modulus});
    else       residue_next = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        residue_q <= '0;
    else if (step) begin
      if (clear)    residue_q <= '0;
      else          residue_q <= residue_next;
    end
  end
endmodule

// File: rtl/fnd_mash.sv
// Three cascaded accumulators with a difference network cancelling the
// quantisation error of the first two stages.
module fnd_mash
  import fnd_pkg::*;
#(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clear,
  input  logic [MOD_W-1:0] frac,
  input  logic [MOD_W-1:0] modulus,
  output offset_t          offset
);
  logic [MOD_W-1:0] addend [ORDER];
  logic [MOD_W-1:0] nxt    [ORDER];
  logic [ORDER-1:0] carry;
  logic             c2_d1, c3_d1, c3_d2;
  logic [3:0]       raw;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign addend[s] = frac;
    end else begin : g_tail
      assign addend[s] = nxt[s-1];
    end
    fnd_accum #(.W(MOD_W)) u_acc (
      .clk          (clk),
      .rst          (rst),
      .step         (step),
      .clear        (clear),
      .addend       (addend[s]),
      .modulus      (modulus),
      .residue_next (nxt[s]),
      .carry        (carry[s])
    );
  end

  // First difference on stage two, second difference on stage three.
  always_comb begin
    raw = 4'(carry[0]) + 4'(carry[1]) - 4'(c2_d1)
        + 4'(carry[2]) - 4'({c3_d1, 1'b0}) + 4'(c3_d2);
    offset = offset_t'(raw);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (step) begin
      if (clear) begin
        c2_d1 <= 1'b0;
        c3_d1 <= 1'b0;
        c3_d2 <= 1'b0;
      end else begin
        c2_d1 <= carry[1];
        c3_d1 <= carry[2];
        c3_d2 <= c3_d1;
      end
    end
  end
endmodule

// File: rtl/fnd_div_counter.sv
// Programmable down-counter over feedback ticks. The first cycle after reset
// primes it; afterwards each completed division reloads it.
module fnd_div_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] next_len,
  output logic         adv,
  output logic         primed,
  output logic         div_pulse,
  output logic [W-1:0] div_len
);
  logic [W-1:0] remain_q;
  logic         finish;

  always_comb begin
    finish = primed && tick && (remain_q == W'(1));
    adv    = !primed || finish;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      remain_q  <= '0;
      div_len   <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= finish;
      if (adv) begin
        primed   <= 1'b1;
        remain_q <= next_len;
        div_len  <= next_len;
      end else if (tick) begin
        remain_q <= remain_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
  import fnd_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_direct,
  input  logic             tick_divided,
  input  logic             src_sel,
  input  logic             frac_en,
  input  logic [INT_W-1:0] int_val,
  input  logic [MOD_W-1:0] frac_val,
  input  logic [MOD_W-1:0] mod_val,
  output logic             div_pulse,
  output logic [INT_W-1:0] div_len
);
  localparam int SUM_W = INT_W + 1;

  logic                    tick_sel;
  logic                    bypass;
  logic                    adv;
  logic                    primed;
  offset_t                 mash_off;
  offset_t                 len_off;
  logic signed [SUM_W-1:0] len_wide;
  logic [INT_W-1:0]        next_len;

  assign tick_sel = src_sel ? tick_divided : tick_direct;
  assign bypass   = !frac_en || (frac_val == '0);

  fnd_mash #(.MOD_W(MOD_W)) u_mash (
    .clk     (clk),
    .rst     (rst),
    .step    (adv),
    .clear   (bypass),
    .frac    (frac_val),
    .modulus (mod_val),
    .offset  (mash_off)
  );

  always_comb begin
    len_off  = bypass ? offset_t'(0) : mash_off;
    len_wide = $signed({1'b0, int_val}) + SUM_W'(len_off);
    next_len = len_wide[INT_W-1:0];
  end

  fnd_div_counter #(.W(INT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_sel),
    .next_len  (next_len),
    .adv       (adv),
    .primed    (primed),
    .div_pulse (div_pulse),
    .div_len   (div_len)
  );
endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick_direct,
  input logic                    tick_divided,
  input logic                    src_sel,
  input logic                    frac_en,
  input logic [INT_W-1:0]        int_val,
  input logic [MOD_W-1:0]        frac_val,
  input logic                    div_pulse,
  input logic [INT_W-1:0]        div_len,
  input logic                    adv,
  input logic                    primed,
  input logic signed [3:0]       mash_off
);
  assert_offset_range_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && frac_en && frac_val != '0) |-> (mash_off >= -4'sd3 && mash_off <= 4'sd4));

  assert_int_len_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !frac_en) |=> (div_len == $past(int_val)));

  assert_zero_frac_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && frac_en && frac_val == '0) |=> (div_len == $past(int_val)));

  assert_pulse_tick_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(src_sel ? tick_divided : tick_direct));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (primed && !(src_sel ? tick_divided : tick_direct)) |=> ($stable(div_len) && !div_pulse));
endmodule

bind fracn_fb_divider fnd_checker #(.INT_W(INT_W), .MOD_W(MOD_W)) u_fnd_checker (
  .clk          (clk),
  .rst          (rst),
  .tick_direct  (tick_direct),
  .tick_divided (tick_divided),
  .src_sel      (src_sel),
  .frac_en      (frac_en),
  .int_val      (int_val),
  .frac_val     (frac_val),
  .div_pulse    (div_pulse),
  .div_len      (div_len),
  .adv          (adv),
  .primed       (primed),
  .mash_off     (mash_off)
);

// File: tb/fracn_fb_divider_test.sv
module fracn_fb_divider_test;
  localparam int INT_W = 16;
  localparam int MOD_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick_direct = 1'b0;
  logic             tick_divided = 1'b0;
  logic             src_sel = 1'b0;
  logic             frac_en = 1'b0;
  logic [INT_W-1:0] int_val = '0;
  logic [MOD_W-1:0] frac_val = '0;
  logic [MOD_W-1:0] mod_val = 12'd8;
  logic             div_pulse;
  logic [INT_W-1:0] div_len;

  fracn_fb_divider #(.INT_W(INT_W), .MOD_W(MOD_W)) uut (
    .clk, .rst, .tick_direct, .tick_divided, .src_sel, .frac_en,
    .int_val, .frac_val, .mod_val, .div_pulse, .div_len
  );

  always #5 clk = ~clk;

  typedef struct {
    int    lo;
    int    hi;
    bit    win;
    string tag;
  } item_t;

  item_t q[$];
  int    pending  = 0;
  int    checks   = 0;
  int    failures = 0;
  int    win_sum  = 0;
  int    win_n    = 0;
  bit    tick_on  = 1'b0;
  bit    done     = 1'b0;
  event  ev_pulse;

  task automatic push(input int n, input int lo, input int hi, input bit win, input string tag);
    for (int k = 0; k < n; k++) begin
      q.push_back('{lo, hi, win, tag});
      pending++;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor and tick driver: one negedge process, no edge races.
  int cnt = 0;
  int cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      cnt += src_sel ? int'(tick_divided) : int'(tick_direct);
      if (div_pulse) begin
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          pending--;
          checks++;
          if (cnt < it.lo || cnt > it.hi) begin
            failures++;
            $display("FAIL %s division ticks actual=%0d expected=%0d..%0d",
                     it.tag, cnt, it.lo, it.hi);
          end
          if (it.win) begin
            win_sum += cnt;
            win_n++;
          end
        end
        cnt = 0;
        -> ev_pulse;
      end
      cyc++;
      tick_direct  <= tick_on;
      tick_divided <= tick_on && (cyc % 3 == 0);
    end
  end

  task automatic run_window(input int n, input int ival, input int f, input int m, input string tag);
    int target;
    win_sum = 0;
    win_n   = 0;
    push(n, ival - 3, ival + 4, 1'b1, "R5");
    wait (pending == 0);
    target = n * ival + (n * f) / m;
    chk(win_n == n, {tag, " window size"}, win_n, n);
    chk(win_sum >= target - 3 && win_sum <= target + 3, tag, win_sum, target);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs idle while reset is held
    chk(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
    chk(div_len == '0, "R1", int'(div_len), 0);

    // R2: integer mode, numerator present but ignored
    int_val  = 16'd5;
    frac_val = 12'd3;
    mod_val  = 12'd8;
    frac_en  = 1'b0;
    push(6, 5, 5, 1'b0, "R2");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    tick_on = 1'b1;
    wait (pending == 0);

    // R7: change right after a pulse; one old-length division first
    @(ev_pulse);
    int_val = 16'd9;
    push(1, 5, 5, 1'b0, "R7");
    push(4, 9, 9, 1'b0, "R7");
    wait (pending == 0);

    // R8: glitch int_val mid-division, restore before it ends
    @(ev_pulse);
    push(1, 9, 9, 1'b0, "R8");
    @(negedge clk);
    @(negedge clk);
    int_val = 16'd4;
    @(negedge clk);
    int_val = 16'd9;
    push(2, 9, 9, 1'b0, "R8");
    wait (pending == 0);

    // R3: count the slower post-divider source
    @(ev_pulse);
    src_sel = 1'b1;
    int_val = 16'd7;
    push(1, 9, 9, 1'b0, "R3");
    push(5, 7, 7, 1'b0, "R3");
    wait (pending == 0);

    // R4: fractional mode with zero numerator
    @(ev_pulse);
    src_sel  = 1'b0;
    frac_en  = 1'b1;
    frac_val = 12'd0;
    int_val  = 16'd6;
    push(1, 7, 7, 1'b0, "R4");
    push(6, 6, 6, 1'b0, "R4");
    wait (pending == 0);

    // R5/R6: 10 + 3/8 over 64 divisions
    @(ev_pulse);
    int_val  = 16'd10;
    frac_val = 12'd3;
    mod_val  = 12'd8;
    push(1, 6, 6, 1'b0, "R7");
    run_window(64, 10, 3, 8, "R6");

    // back to integer mode to clear the modulator
    @(ev_pulse);
    frac_en = 1'b0;
    int_val = 16'd5;
    push(1, 7, 14, 1'b0, "R5");
    push(2, 5, 5, 1'b0, "R2");
    wait (pending == 0);

    // R5/R6: 20 + 5/7 over 70 divisions
    @(ev_pulse);
    frac_en  = 1'b1;
    int_val  = 16'd20;
    frac_val = 12'd5;
    mod_val  = 12'd7;
    push(1, 5, 5, 1'b0, "R7");
    run_window(70, 20, 5, 7, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired pending=%0d", pending);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule